// File: doc/BRIEF.md
# Iterative Tree Sum Reduction Engine

This block holds a bank of signed integer elements and folds them into one sum over a series of halving rounds, the way a group of parallel lanes would share a reduction. A host writes the elements one at a time through an indexed write port. It then raises a one-cycle start strobe together with the number of elements to reduce. While the engine works it holds a busy flag. When it finishes it raises a one-cycle done strobe and presents the total on a registered sum output.

In every round the active count is examined first. If the count is odd, the last active element is added into slot 0. The count is then halved with integer division. Every slot below the new half adds in its partner that sits exactly half a span above it. All lanes update in the same clock cycle. Rounds stop when one active element is left, and slot 0 then holds the total.

Any element count from 1 up to the bank size is handled, whether or not it is a power of two. The reduction overwrites the bank, so the host reloads the elements before the next run.

Top module: `tree_sum_engine`

## Requirements
- R1: After synchronous reset, busy, done and sum all read 0.
- R2: A write with wr_en high and wr_idx below NUM_ELEM stores wr_data into that slot while the engine is idle. A write whose wr_idx is NUM_ELEM or above changes no slot.
- R3: A start strobe while idle is accepted. Busy reads 1 after the accepting edge. A count of 0 is treated as 1, and a count above NUM_ELEM is treated as NUM_ELEM.
- R4: For an effective count C, the sum reported with done equals the sum of slots 0 to C-1, wrapped modulo 2^ELEM_W, with no overflow indication.
- R5: Each round folds the last active element into slot 0 when the active count is odd. It then halves the count, and each slot below the half adds its partner at index plus half. Odd counts at any round therefore give the exact total.
- R6: Done rises floor(log2 C)+1 rising edges after the accepting edge. Busy stays 1 on every cycle in between and reads 0 together with done.
- R7: Done is high for exactly one cycle. Sum changes only on the cycle done is high and holds its value until the next done.
- R8: A start strobe while busy is ignored, and so is the count presented with it. Neither the result nor the latency changes.
- R9: A write while busy, or in the same cycle as an accepted start, changes no slot.
- R10: An effective count of 1 raises done one edge after the accepting edge, and sum equals slot 0 unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Element write strobe |
| wr_idx | input | $clog2(NUM_ELEM) | Slot index for the write |
| wr_data | input | ELEM_W | Element value to write |
| start | input | 1 | Start strobe for a reduction |
| count | input | $clog2(NUM_ELEM+1) | Number of elements to reduce |
| busy | output | 1 | High while a reduction is running |
| done | output | 1 | One-cycle strobe when the sum is valid |
| sum | output | ELEM_W | Wrapped total, held until the next done |

## Verification
A lane that adds the wrong partner, or an odd count whose stray element is lost, shows at the ports as a wrong sum on the done cycle of that run. The run is short, lasting floor(log2 C)+1 cycles, so the error appears within a handful of cycles. A wrong halving of the count shifts the cycle on which done rises, which the latency count exposes on the same run. A control state that still accepts start or writes during a run shows as a changed total or a changed latency on that run.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } tsr_phase_e;

  // rounds needed to bring a count down to one
  function automatic int unsigned tsr_rounds(input int unsigned c);
    int unsigned r;
    int unsigned v;
    r = 0;
    v = c;
    while (v > 1) begin
      v = v / 2;
      r = r + 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/tsr_ctrl.sv
module tsr_ctrl
  import tsr_pkg::*;
#(
  parameter int NUM_ELEM = 10,
  parameter int CNT_W    = $clog2(NUM_ELEM + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] count_in,
  output logic             busy,
  output logic             round_en,
  output logic             capture,
  output logic             done,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] half,
  output logic             odd
);

  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(NUM_ELEM);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  tsr_phase_e       phase_q;
  logic             accept;
  logic [CNT_W-1:0] cnt_eff;

  assign accept = start && (phase_q == PH_IDLE);

  always_comb begin
    if (count_in == '0)
      cnt_eff = ONE_C;
    else if (count_in > MAX_C)
      cnt_eff = MAX_C;
    else
      cnt_eff = count_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (accept) begin
            phase_q <= PH_RUN;
            cnt_q   <= cnt_eff;
          end
        end
        PH_RUN: begin
          if (cnt_q > ONE_C) begin
            cnt_q <= cnt_q >> 1;
          end else begin
            phase_q <= PH_IDLE;
            done    <= 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy     = (phase_q == PH_RUN);
  assign round_en = busy && (cnt_q > ONE_C);
  assign capture  = busy && (cnt_q == ONE_C);
  assign half     = cnt_q >> 1;
  assign odd      = cnt_q[0];

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt_q > ONE_C) |=> (busy && cnt_q < $past(cnt_q)));

  // R6
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

endmodule

// File: rtl/tsr_bank.sv
module tsr_bank #(
  parameter int NUM_ELEM = 10,
  parameter int ELEM_W   = 16,
  parameter int IDX_W    = $clog2(NUM_ELEM),
  parameter int CNT_W    = $clog2(NUM_ELEM + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ELEM_W-1:0] wr_data,
  input  logic              round_en,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  half,
  input  logic              odd,
  output logic [ELEM_W-1:0] head
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(NUM_ELEM);

  logic [ELEM_W-1:0] slot_q   [NUM_ELEM];
  logic [ELEM_W-1:0] lane_nxt [NUM_ELEM];
  logic [NUM_ELEM-1:0] lane_act;
  logic              wr_ok;

  assign wr_ok = wr_en && ({{(CNT_W-IDX_W){1'b0}}, wr_idx} < LIMIT);

  for (genvar g = 0; g < NUM_ELEM; g++) begin : g_lane
    localparam logic [CNT_W-1:0] LANE = CNT_W'(g);
    logic [CNT_W-1:0]  pidx;
    logic [ELEM_W-1:0] partner;

    assign pidx     = LANE + half;
    assign partner  = (pidx < LIMIT) ? slot_q[pidx[IDX_W-1:0]] : '0;
    assign lane_act[g] = (LANE < half);

    if (g == 0) begin : g_head
      logic [CNT_W-1:0]  tidx;
      logic [ELEM_W-1:0] stray;
      assign tidx  = cnt - CNT_W'(1);
      assign stray = (odd && tidx < LIMIT) ? slot_q[tidx[IDX_W-1:0]] : '0;
      assign lane_nxt[g] = slot_q[g] + partner + stray;
    end else begin : g_body
      assign lane_nxt[g] = slot_q[g] + partner;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_ELEM; i++) begin
      if (wr_ok && wr_idx == IDX_W'(i))
        slot_q[i] <= wr_data;
      else if (round_en && lane_act[i])
        slot_q[i] <= lane_nxt[i];
    end
  end

  assign head = slot_q[0];

  // R9
  head_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!round_en && !wr_en) |=> (head == $past(head)));

  // R2
  head_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == '0) |=> (head == $past(wr_data)));

  // R9
  excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && round_en));

endmodule

// File: rtl/tree_sum_engine.sv
module tree_sum_engine
  import tsr_pkg::*;
#(
  parameter int NUM_ELEM = 10,
  parameter int ELEM_W   = 16,
  localparam int IDX_W   = $clog2(NUM_ELEM),
  localparam int CNT_W   = $clog2(NUM_ELEM + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ELEM_W-1:0] wr_data,
  input  logic              start,
  input  logic [CNT_W-1:0]  count,
  output logic              busy,
  output logic              done,
  output logic [ELEM_W-1:0] sum
);

  logic             round_en;
  logic             capture;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half;
  logic             odd;
  logic             wr_gate;
  logic [ELEM_W-1:0] head;
  logic [ELEM_W-1:0] sum_q;

  // writes only land while idle and not alongside an accepted start
  assign wr_gate = wr_en && !busy && !start;

  tsr_ctrl #(
    .NUM_ELEM (NUM_ELEM),
    .CNT_W    (CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .count_in (count),
    .busy     (busy),
    .round_en (round_en),
    .capture  (capture),
    .done     (done),
    .cnt_q    (cnt_q),
    .half     (half),
    .odd      (odd)
  );

  tsr_bank #(
    .NUM_ELEM (NUM_ELEM),
    .ELEM_W   (ELEM_W),
    .IDX_W    (IDX_W),
    .CNT_W    (CNT_W)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_gate),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .round_en (round_en),
    .cnt      (cnt_q),
    .half     (half),
    .odd      (odd),
    .head     (head)
  );

  always_ff @(posedge clk) begin
    if (rst)
      sum_q <= '0;
    else if (capture)
      sum_q <= head;
  end

  assign sum = sum_q;

  // R7
  sum_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sum_q) |-> done);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !done && sum_q == '0));

endmodule

// File: tb/tree_sum_engine_test.sv
`timescale 1ns/1ps
module tree_sum_engine_test;
  import tsr_pkg::*;

  localparam int N  = 10;
  localparam int W  = 16;
  localparam int IW = $clog2(N);
  localparam int CW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [W-1:0]  wr_data = '0;
  logic          start = 1'b0;
  logic [CW-1:0] count = '0;
  logic          busy;
  logic          done;
  logic [W-1:0]  sum;

  logic [W-1:0] model [N];
  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  tree_sum_engine #(.NUM_ELEM(N), .ELEM_W(W)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .start(start), .count(count),
    .busy(busy), .done(done), .sum(sum)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_sum(input int c);
    logic [W-1:0] s;
    s = '0;
    for (int i = 0; i < c; i++) s = s + model[i];
    return s;
  endfunction

  function automatic int eff_count(input int c);
    if (c == 0) return 1;
    if (c > N) return N;
    return c;
  endfunction

  task automatic write_el(input int idx, input logic [W-1:0] v);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    if (idx < N) model[idx] = v;
  endtask

  task automatic load_random();
    for (int i = 0; i < N; i++) write_el(i, W'($urandom));
  endtask

  task automatic load_const(input logic [W-1:0] v);
    for (int i = 0; i < N; i++) write_el(i, v);
  endtask

  // inj: 0 none, 1 start+write while busy, 2 write alongside start
  task automatic run(input int c, input int inj, input string req);
    int ce;
    int lat;
    bit busy_bad;
    logic [W-1:0] exp;
    logic [W-1:0] got;
    ce  = eff_count(c);
    exp = exp_sum(ce);
    busy_bad = 0;
    start = 1'b1; count = CW'(c);
    if (inj == 2) begin
      wr_en = 1'b1; wr_idx = '0; wr_data = ~model[0];
    end
    @(negedge clk);
    start = 1'b0; wr_en = 1'b0;
    lat = 1;
    while (!done && lat < 60) begin
      if (!busy) busy_bad = 1;
      if (lat == 1 && inj == 1) begin
        start = 1'b1; count = CW'(1);
        wr_en = 1'b1; wr_idx = '0; wr_data = model[0] + 16'd77;
      end else begin
        start = 1'b0; wr_en = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0; wr_en = 1'b0;
    check(done === 1'b1, req, "done seen", done, 1);
    check(sum === exp, req, "sum (R4/R5)", sum, exp);
    check((lat - 1) == int'(tsr_rounds(ce)) + 1, "R6", "latency", lat - 1,
          tsr_rounds(ce) + 1);
    check(!busy_bad && busy === 1'b0, "R6", "busy window", busy, 0);
    got = sum;
    @(negedge clk);
    check(done === 1'b0, "R7", "done width", done, 0);
    check(sum === got, "R7", "sum held", sum, got);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1
    check(busy === 1'b0, "R1", "busy", busy, 0);
    check(done === 1'b0, "R1", "done", done, 0);
    check(sum === '0, "R1", "sum", sum, 0);
    rst = 1'b0;
    @(negedge clk);

    // R10 single element
    load_random();
    run(1, 0, "R10");
    load_random();
    run(0, 0, "R3");
    // directed counts, odd and even
    load_random(); run(2, 0, "R4");
    load_random(); run(3, 0, "R5");
    load_random(); run(7, 0, "R5");
    load_random(); run(N, 0, "R4");
    load_random(); run(15, 0, "R3");
    // wrap
    load_const(16'hFFFF); run(N, 0, "R4");
    load_const(16'h7FFF); run(5, 0, "R4");
    // R2 out-of-range write must not land
    load_random();
    write_el(12, 16'h1234);
    write_el(15, 16'h4321);
    run(N, 0, "R2");
    // R8 and R9
    load_random(); run(6, 1, "R8");
    load_random(); run(N, 1, "R9");
    load_random(); run(4, 2, "R9");
    // random mix
    for (int k = 0; k < 40; k++) begin
      load_random();
      run(int'($urandom_range(0, 15)), (k % 5 == 0) ? 1 : ((k % 7 == 0) ? 2 : 0),
          "R4");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule